// File: doc/BRIEF.md
# LCD Common/Segment Drive Sequencer

This block produces the multiplexed drive waveforms for a small LCD panel as 2-bit level codes, one per common line and one per segment line. An external analog stage turns each code into one of four bias voltages. The block supports static, 1/2, 1/3 and 1/4 duty. It keeps its own scan counter, which picks the selected common line, and its own frame-alternation phase bit. It reads the segment pattern for the selected common line from a display RAM through a combinational read port.

A gate decides whether the display runs. It looks at the activate bit, the chip power mode, and whether the operating clock is derived from the sub-clock. When the display is stopped, every line is parked at VSS, so no DC bias is left across the panel. The same gate also produces the drive-supply enable from the power-switch bit and the power mode.

Top module: `lcd_drive_seq`

## Requirements
- R1: While rst_ni is low, every com_o and seg_o code is 2'b00 (VSS), m_o is 0 and ram_addr_o is 0.
- R2: When act_i is 0, the display is stopped. All level codes read VSS from the next clock edge, and the scan index and m_o return to 0.
- R3: The display runs in power modes 0 (active) and 1 (sleep). In modes 2 (watch), 3 (subactive) and 4 (subsleep) it runs only when clk_sub_i is 1. In modes 5 (standby), 6 (module standby) and 7 it is stopped, as described in R2.
- R4: supply_en_o is psw_i, except that it is forced to 0 in mode 5 (standby).
- R5: duty_i selects the duty: 0 static, 1 half, 2 third, 3 quarter, giving N = duty_i+1 common lines. While running, a prescaler issues one step every TICK_DIV cycles. At each step, ram_addr_o (the selected common line) advances by one. It wraps to 0 when the index is N-1 or above.
- R6: m_o toggles exactly at a step where the index wraps to 0, that is, once per frame.
- R7: Level codes are 00=VSS, 01=V3, 10=V2, 11=V1. In static duty, com line 0 is V1 when m=0 and VSS when m=1. A segment with data 0 takes the same code as com line 0. A segment with data 1 takes the opposite code: VSS when m=0, V1 when m=1.
- R8: In 1/2 duty, the selected common line is V1 (m=0) or VSS (m=1). The other common line is V2 in both phases. Segment codes follow the static rule in R7.
- R9: In 1/3 and 1/4 duty, the selected common line is V1 (m=0) or VSS (m=1), and unselected lines are V3 (m=0) or V2 (m=1). A segment with data 0 is V2 (m=0) or V3 (m=1). A segment with data 1 is VSS (m=0) or V1 (m=1).
- R10: Common lines with an index of N or above are held at VSS.
- R11: Level outputs are registered. The codes seen after a clock edge reflect the scan index, m_o, RAM data, duty and run state present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty_i | input | 2 | Duty select (0 static, 1 half, 2 third, 3 quarter) |
| act_i | input | 1 | Display activate |
| pwr_mode_i | input | 3 | Chip power mode code |
| clk_sub_i | input | 1 | 1 when the operating clock is sub-clock derived |
| psw_i | input | 1 | Drive-supply power switch request |
| ram_addr_o | output | 2 | Display RAM row (selected common line) |
| ram_rdata_i | input | NUM_SEG | Segment data for the addressed row |
| com_o | output | 2*NUM_COM | Common level codes, line c in bits [2c+1:2c] |
| seg_o | output | 2*NUM_SEG | Segment level codes, line s in bits [2s+1:2s] |
| m_o | output | 1 | Frame-alternation phase |
| supply_en_o | output | 1 | Drive-supply enable |

## Verification
The level codes show up one clock edge after the state and data they depend on. The scan index and m_o change on the edge of a prescaler step. supply_en_o follows its inputs within the same cycle. The bench runs a reference model that, at each rising edge, computes the expected codes from the pre-edge state and then advances its own scan state. It queues that result as one expected item, and a monitor pops the item and compares it at the following falling edge. The supply enable and the reset state are checked directly, one falling edge after their inputs change.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int unsigned NUM_COM = 4;

  typedef enum logic [1:0] {
    LVL_VSS = 2'b00,
    LVL_V3  = 2'b01,
    LVL_V2  = 2'b10,
    LVL_V1  = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    DUTY_STATIC  = 2'd0,
    DUTY_HALF    = 2'd1,
    DUTY_THIRD   = 2'd2,
    DUTY_QUARTER = 2'd3
  } duty_e;

  typedef enum logic [2:0] {
    PM_ACTIVE   = 3'd0,
    PM_SLEEP    = 3'd1,
    PM_WATCH    = 3'd2,
    PM_SUBACT   = 3'd3,
    PM_SUBSLEEP = 3'd4,
    PM_STANDBY  = 3'd5,
    PM_MSTBY    = 3'd6,
    PM_RSVD     = 3'd7
  } pmode_e;

  // pick a level by frame phase
  function automatic lvl_e by_phase(input logic m, input lvl_e lvl_m0, input lvl_e lvl_m1);
    return m ? lvl_m1 : lvl_m0;
  endfunction
endpackage

// File: rtl/lcd_run_gate.sv
module lcd_run_gate
  import lcd_drv_pkg::*;
(
  input  logic       act_i,
  input  logic [2:0] pwr_mode_i,
  input  logic       clk_sub_i,
  input  logic       psw_i,
  output logic       run_o,
  output logic       supply_en_o
);
  logic clk_ok;

  always_comb begin
    unique case (pmode_e'(pwr_mode_i))
      PM_ACTIVE, PM_SLEEP:               clk_ok = 1'b1;
      PM_WATCH, PM_SUBACT, PM_SUBSLEEP:  clk_ok = clk_sub_i;
      default:                           clk_ok = 1'b0;
    endcase
  end

  assign run_o       = act_i & clk_ok;
  assign supply_en_o = psw_i & (pmode_e'(pwr_mode_i) != PM_STANDBY);
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] duty_i,
  output logic [1:0] idx_o,
  output logic       m_o
);
  localparam int unsigned PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [1:0]       idx_q;
  logic             m_q;
  logic             step;
  logic             wrap;

  assign step = run_i && (pre_q == PRE_LAST);
  // index at or past the last line closes the frame
  assign wrap = (idx_q >= duty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      idx_q <= '0;
      m_q   <= 1'b0;
    end else if (!run_i) begin
      pre_q <= '0;
      idx_q <= '0;
      m_q   <= 1'b0;
    end else if (step) begin
      pre_q <= '0;
      if (wrap) begin
        idx_q <= '0;
        m_q   <= ~m_q;
      end else begin
        idx_q <= idx_q + 2'd1;
      end
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  assign idx_o = idx_q;
  assign m_o   = m_q;
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_drv_pkg::*;
#(
  parameter int unsigned NUM_SEG = 8
) (
  input  logic [1:0]           duty_i,
  input  logic [1:0]           idx_i,
  input  logic                 m_i,
  input  logic [NUM_SEG-1:0]   data_i,
  output logic [2*NUM_COM-1:0] com_lvl_o,
  output logic [2*NUM_SEG-1:0] seg_lvl_o
);
  logic two_level;
  assign two_level = (duty_i == DUTY_STATIC) || (duty_i == DUTY_HALF);

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    logic sel;
    lvl_e lvl;
    assign sel = (duty_i == DUTY_STATIC) || (idx_i == 2'(c));
    always_comb begin
      if (duty_i < 2'(c))            lvl = LVL_VSS;
      else if (sel)                  lvl = by_phase(m_i, LVL_V1, LVL_VSS);
      else if (duty_i == DUTY_HALF)  lvl = LVL_V2;
      else                           lvl = by_phase(m_i, LVL_V3, LVL_V2);
    end
    assign com_lvl_o[2*c +: 2] = lvl;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    lvl_e lvl;
    always_comb begin
      if (data_i[s])       lvl = by_phase(m_i, LVL_VSS, LVL_V1);
      else if (two_level)  lvl = by_phase(m_i, LVL_V1, LVL_VSS);
      else                 lvl = by_phase(m_i, LVL_V2, LVL_V3);
    end
    assign seg_lvl_o[2*s +: 2] = lvl;
  end
endmodule

// File: rtl/lcd_drive_seq.sv
module lcd_drive_seq
  import lcd_drv_pkg::*;
#(
  parameter int unsigned NUM_SEG  = 8,
  parameter int unsigned TICK_DIV = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           duty_i,
  input  logic                 act_i,
  input  logic [2:0]           pwr_mode_i,
  input  logic                 clk_sub_i,
  input  logic                 psw_i,
  output logic [1:0]           ram_addr_o,
  input  logic [NUM_SEG-1:0]   ram_rdata_i,
  output logic [2*NUM_COM-1:0] com_o,
  output logic [2*NUM_SEG-1:0] seg_o,
  output logic                 m_o,
  output logic                 supply_en_o
);
  localparam int unsigned COM_W = 2 * NUM_COM;
  localparam int unsigned SEG_W = 2 * NUM_SEG;

  logic             run;
  logic [1:0]       idx;
  logic             m;
  logic [COM_W-1:0] com_lvl, com_q;
  logic [SEG_W-1:0] seg_lvl, seg_q;

  lcd_run_gate i_gate (
    .act_i       (act_i),
    .pwr_mode_i  (pwr_mode_i),
    .clk_sub_i   (clk_sub_i),
    .psw_i       (psw_i),
    .run_o       (run),
    .supply_en_o (supply_en_o)
  );

  lcd_scan_ctrl #(.TICK_DIV(TICK_DIV)) i_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .duty_i (duty_i),
    .idx_o  (idx),
    .m_o    (m)
  );

  lcd_level_map #(.NUM_SEG(NUM_SEG)) i_map (
    .duty_i    (duty_i),
    .idx_i     (idx),
    .m_i       (m),
    .data_i    (ram_rdata_i),
    .com_lvl_o (com_lvl),
    .seg_lvl_o (seg_lvl)
  );

  // park every line at VSS when stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      com_q <= '0;
      seg_q <= '0;
    end else if (!run) begin
      com_q <= '0;
      seg_q <= '0;
    end else begin
      com_q <= com_lvl;
      seg_q <= seg_lvl;
    end
  end

  assign ram_addr_o = idx;
  assign m_o        = m;
  assign com_o      = com_q;
  assign seg_o      = seg_q;
endmodule

// File: rtl/lcd_drive_seq_chk.sv
module lcd_drive_seq_chk #(
  parameter int unsigned NUM_SEG = 8,
  parameter int unsigned NUM_COM = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [1:0]           duty_i,
  input logic                 act_i,
  input logic [2:0]           pwr_mode_i,
  input logic                 supply_en_o,
  input logic [1:0]           ram_addr_o,
  input logic [2*NUM_COM-1:0] com_o,
  input logic [2*NUM_SEG-1:0] seg_o,
  input logic                 m_o
);
  function automatic logic outer_only(input logic [2*NUM_SEG-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int s = 0; s < NUM_SEG; s++)
      if (v[2*s +: 2] != 2'b00 && v[2*s +: 2] != 2'b11) ok = 1'b0;
    return ok;
  endfunction

  // R2
  stop_parks_vss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> (com_o == '0 && seg_o == '0));

  // R4
  standby_supply_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_mode_i == 3'd5 |-> !supply_en_o);

  // R5
  scan_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_addr_o != $past(ram_addr_o) |->
      (ram_addr_o == $past(ram_addr_o) + 2'd1 || ram_addr_o == 2'd0));

  // R6
  phase_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_o != $past(m_o) |-> ram_addr_o == 2'd0);

  // R10
  static_unused_com_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(duty_i) == 2'd0 |-> com_o[2*NUM_COM-1:2] == '0);

  // R7
  two_level_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(duty_i) <= 2'd1 |-> outer_only(seg_o));
endmodule

bind lcd_drive_seq lcd_drive_seq_chk #(.NUM_SEG(NUM_SEG), .NUM_COM(lcd_drv_pkg::NUM_COM)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .duty_i      (duty_i),
  .act_i       (act_i),
  .pwr_mode_i  (pwr_mode_i),
  .supply_en_o (supply_en_o),
  .ram_addr_o  (ram_addr_o),
  .com_o       (com_o),
  .seg_o       (seg_o),
  .m_o         (m_o)
);

// File: tb/test_lcd_drive_seq.sv
`timescale 1ns/1ps
module test_lcd_drive_seq;
  localparam int unsigned NSEG = 8;
  localparam int unsigned NCOM = 4;
  localparam int unsigned TDIV = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      duty = 2'd3;
  logic            act = 1'b0;
  logic [2:0]      pmode = 3'd0;
  logic            clk_sub = 1'b0;
  logic            psw = 1'b0;
  logic [1:0]      ram_addr;
  logic [NSEG-1:0] ram_rdata;
  logic [2*NCOM-1:0] com;
  logic [2*NSEG-1:0] seg;
  logic            m;
  logic            supply_en;

  logic [NSEG-1:0] mem [4];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign ram_rdata = mem[ram_addr];

  lcd_drive_seq #(.NUM_SEG(NSEG), .TICK_DIV(TDIV)) i_lcd_drive_seq (
    .clk_i(clk), .rst_ni(rst_n), .duty_i(duty), .act_i(act), .pwr_mode_i(pmode),
    .clk_sub_i(clk_sub), .psw_i(psw), .ram_addr_o(ram_addr), .ram_rdata_i(ram_rdata),
    .com_o(com), .seg_o(seg), .m_o(m), .supply_en_o(supply_en)
  );

  typedef struct {
    logic [2*NCOM-1:0] com;
    logic [2*NSEG-1:0] seg;
    logic              m;
    logic [1:0]        addr;
    string             tag;
  } item_t;

  item_t sb_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  function automatic logic [1:0] ph(input logic mm, input logic [1:0] a, input logic [1:0] b);
    return mm ? b : a;
  endfunction

  function automatic bit runs(input logic a, input logic [2:0] pm, input logic sub);
    if (!a) return 0;
    if (pm <= 3'd1) return 1;
    if (pm <= 3'd4) return sub;
    return 0;
  endfunction

  // reference scan state
  int         r_pre = 0;
  logic [1:0] r_idx = 2'd0;
  logic       r_m = 1'b0;

  task automatic push_expect(input item_t it);
    sb_q.push_back(it);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_pre = 0; r_idx = 2'd0; r_m = 1'b0;
      sb_q.delete();
    end else begin
      item_t it;
      bit    rn;
      rn = runs(act, pmode, clk_sub);
      it.com = '0; it.seg = '0;
      if (rn) begin
        for (int c = 0; c < NCOM; c++) begin
          if (c > duty)                          it.com[2*c +: 2] = 2'b00;   // R10
          else if (duty == 2'd0 || c == r_idx)   it.com[2*c +: 2] = ph(r_m, 2'b11, 2'b00);
          else if (duty == 2'd1)                 it.com[2*c +: 2] = 2'b10;   // R8
          else                                   it.com[2*c +: 2] = ph(r_m, 2'b01, 2'b10); // R9
        end
        for (int s = 0; s < NSEG; s++) begin
          if (mem[r_idx][s])    it.seg[2*s +: 2] = ph(r_m, 2'b00, 2'b11);
          else if (duty <= 2'd1) it.seg[2*s +: 2] = ph(r_m, 2'b11, 2'b00); // R7
          else                   it.seg[2*s +: 2] = ph(r_m, 2'b10, 2'b01);
        end
        it.tag = (duty == 2'd0) ? "R7" : (duty == 2'd1) ? "R8" : "R9";
      end else begin
        it.tag = act ? "R3" : "R2";
      end
      if (!rn) begin
        r_pre = 0; r_idx = 2'd0; r_m = 1'b0;
      end else if (r_pre == TDIV - 1) begin
        r_pre = 0;
        if (r_idx >= duty) begin r_idx = 2'd0; r_m = ~r_m; end
        else r_idx = r_idx + 2'd1;
      end else begin
        r_pre++;
      end
      it.m = r_m;
      it.addr = r_idx;
      push_expect(it);
    end
  end

  // monitor: one item per rising edge, compared at the following falling edge (R11)
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(com == it.com, {it.tag, " com"}, 32'(com), 32'(it.com));
      check(seg == it.seg, {it.tag, " seg R11"}, 32'(seg), 32'(it.seg));
      check(m == it.m, "R6 phase", 32'(m), 32'(it.m));
      check(ram_addr == it.addr, "R5 scan index", 32'(ram_addr), 32'(it.addr));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h0F; mem[3] = 8'hF0;
    cyc(3);
    // R1 reset state
    check(com == '0, "R1 com", 32'(com), 0);
    check(seg == '0, "R1 seg", 32'(seg), 0);
    check(m == 1'b0, "R1 m", 32'(m), 0);
    check(ram_addr == 2'd0, "R1 addr", 32'(ram_addr), 0);
    rst_n = 1'b1;
    act = 1'b1; psw = 1'b1;
    cyc(1);
    // R4 supply enable
    check(supply_en == 1'b1, "R4 active psw", 32'(supply_en), 1);
    duty = 2'd3; cyc(80);                 // R9 quarter
    duty = 2'd2; cyc(60);                 // R9 third
    mem[0] = 8'h5A; mem[1] = 8'hC3; mem[2] = 8'hFF; mem[3] = 8'h00;
    cyc(30);
    duty = 2'd1; cyc(40);                 // R8 half
    duty = 2'd3; cyc(13);
    duty = 2'd0; cyc(30);                 // R7 static, stale index wraps (R5)
    duty = 2'd3; cyc(20);
    act = 1'b0; cyc(10);                  // R2
    act = 1'b1; cyc(20);
    pmode = 3'd2; clk_sub = 1'b0; cyc(10); // R3 watch without sub-clock
    clk_sub = 1'b1; cyc(1);
    check(supply_en == 1'b1, "R4 watch psw", 32'(supply_en), 1);
    cyc(40);
    pmode = 3'd3; cyc(20);
    pmode = 3'd4; cyc(20);
    clk_sub = 1'b0; cyc(10);
    pmode = 3'd5; cyc(1);
    check(supply_en == 1'b0, "R4 standby forced off", 32'(supply_en), 0);
    cyc(10);
    pmode = 3'd6; cyc(1);
    check(supply_en == 1'b1, "R4 module standby psw", 32'(supply_en), 1);
    cyc(10);
    pmode = 3'd7; cyc(8);
    pmode = 3'd1; cyc(40);                // R3 sleep runs
    psw = 1'b0; cyc(1);
    check(supply_en == 1'b0, "R4 psw off", 32'(supply_en), 0);
    pmode = 3'd0; duty = 2'd2; cyc(30);
    rst_n = 1'b0; cyc(2);
    check(com == '0 && seg == '0, "R1 reset mid-run", 32'(com), 0);
    check(ram_addr == 2'd0 && m == 1'b0, "R1 reset scan", 32'({ram_addr, m}), 0);
    done = 1;
    finish_run();
  end
endmodule